// File: doc/BRIEF.md
# Time-Multiplexed Colour Palette

This block is the colour lookup stage of a video pipeline. It turns bitplane pixel indices into 12-bit RGB pixels. Its colour register file can be read only once per low-resolution pixel period, called a slow cycle. The block runs on a single clock at the fastest pixel rate. A phase counter divides each slow cycle into four clocks, and every lookup happens on the clock edge that starts a slow cycle.

There are three pixel modes. In low-resolution mode, one lookup produces one pixel per slow cycle. In high-resolution mode, the 32 registers are treated as two 16-entry banks that are read in parallel, one per pixel, so each slow cycle yields two pixels. In double-rate mode, a single 12-bit entry is read and its two 6-bit halves are sent out as two pixels on consecutive clocks. Each half is widened to 12-bit RGB, so this mode can show only 64 colours.

A CPU port writes colour registers. A write is held until the next slow-cycle boundary before it takes effect. A mode change also waits for a boundary, and the pixels of the first slow cycle after the change are blanked.

Top module: `palette_tmux`

## Requirements
- R1: While reset is asserted, `pix_valid` is 0 and `pix_rgb` is 0. After reset, every colour register reads as 0.
- R2: The block samples `mode_req`, `sel_a` and `sel_b` on the first clock edge after reset and on every fourth edge after that (the boundary edges). In low-resolution mode (`mode_req` = 0), the entry `sel_a` appears on `pix_rgb` after the following edge. `pix_valid` is high for that one clock only, and `pix_rgb` holds its value for the rest of the slow cycle.
- R3: In high-resolution mode (`mode_req` = 1), the first pixel is entry `{0, sel_a[3:0]}` and appears after the edge that follows the boundary. The second pixel is entry `{1, sel_b}` and appears two edges later. `pix_valid` is high for exactly these two clocks.
- R4: In double-rate mode (`mode_req` = 2), entry `sel_a` is read. Its bits [11:6] are output after the edge that follows the boundary, and its bits [5:0] after the next edge, with `pix_valid` high for both clocks. Each 6-bit value is laid out as {r[1:0], g[1:0], b[1:0]}. Each channel is widened to 4 bits by repeating its 2 bits.
- R5: The code `mode_req` = 3 behaves exactly like low-resolution mode. A switch between codes 0 and 3 does not count as a mode change.
- R6: A write (`cpu_we`, `cpu_addr`, `cpu_wdata`) is applied at the next boundary edge. The lookup made at that same edge still returns the old value. A write presented on a boundary edge itself waits for the following boundary.
- R7: If more than one write arrives before a boundary, only the last one is applied. The registers addressed by the earlier writes keep their old contents.
- R8: `mode_req` matters only at a boundary edge. When the sampled mode differs from the active one, the new mode takes over. For the slow cycle just started, `pix_valid` stays 0 and `pix_rgb` is driven to 0.
- R9: In high-resolution mode, `sel_a[4]` has no effect on the colour output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fastest pixel-rate clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| cpu_we | input | 1 | Colour register write strobe |
| cpu_addr | input | 5 | Colour register index to write |
| cpu_wdata | input | 12 | Colour value {r[3:0], g[3:0], b[3:0]} |
| mode_req | input | 2 | 0 low-res, 1 high-res, 2 double-rate, 3 low-res |
| sel_a | input | 5 | Pixel index of the first (or only) pixel of a slow cycle |
| sel_b | input | 4 | High-resolution index of the second pixel |
| pix_rgb | output | 12 | RGB pixel {r, g, b}, 4 bits each |
| pix_valid | output | 1 | High on each clock that presents a new pixel |

## Verification
A phase counter that slips shows up within one slow cycle: valid pulses move away from their fixed offsets after the boundary, and colours are taken from indices sampled on the wrong edge. A pending write that is lost, applied early, or applied to the wrong entry shows up one or two slow cycles later as a wrong colour for that index. The sweeps read every entry in every mode, so any such fault is reached. A wrong mode or blanking flag changes the spacing of `pix_valid` in the very next slow cycle, and a change that is not blanked lets non-zero pixels through in the cycle that should be dark.

// File: rtl/palette_tmux_pkg.sv
package palette_tmux_pkg;

  // Pixel mode held while a slow cycle runs
  typedef enum logic [1:0] {
    PM_LORES = 2'd0,
    PM_HIRES = 2'd1,
    PM_DBL   = 2'd2
  } pmode_e;

  // Fast clocks per slow lookup cycle
  localparam int unsigned PH_N = 4;
  localparam int unsigned PH_W = $clog2(PH_N);

  // Code 3 is folded onto low-resolution
  function automatic pmode_e fold_mode(input logic [1:0] code);
    pmode_e m;
    case (code)
      2'd1:    m = PM_HIRES;
      2'd2:    m = PM_DBL;
      default: m = PM_LORES;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/palette_regs.sv
module palette_regs
  import palette_tmux_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [COL_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr_a,
  input  logic [IDX_W-1:0] rd_addr_b,
  output logic [COL_W-1:0] rd_data_a,
  output logic [COL_W-1:0] rd_data_b
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [COL_W-1:0] mem [ENTRIES];
  logic             pend_v, pend_v_n;
  logic [IDX_W-1:0] pend_a, pend_a_n;
  logic [COL_W-1:0] pend_d, pend_d_n;
  logic [ENTRIES-1:0] hit;

  // One-deep holding slot: the last write before a boundary wins (R7)
  always_comb begin
    pend_v_n = pend_v;
    pend_a_n = pend_a;
    pend_d_n = pend_d;
    if (commit) pend_v_n = 1'b0;
    if (wr_en) begin
      pend_v_n = 1'b1;
      pend_a_n = wr_addr;
      pend_d_n = wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      hit[i] = commit && pend_v && (pend_a == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else begin
      pend_v <= pend_v_n;
      pend_a <= pend_a_n;
      pend_d <= pend_d_n;
    end
  end

  // Entries change only on a boundary edge (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(ENTRIES); i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < int'(ENTRIES); i++) begin
        if (hit[i]) mem[i] <= pend_d;
      end
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];

endmodule

// File: rtl/palette_seq.sv
module palette_seq
  import palette_tmux_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_req,
  output logic [PH_W-1:0] ph,
  output logic            boundary,
  output pmode_e          mode_sel,
  output pmode_e          mode_act,
  output logic            blank
);

  logic [PH_W-1:0] ph_n;
  pmode_e          mode_act_n;
  logic            blank_n;

  assign boundary = (ph == '0);
  assign mode_sel = fold_mode(mode_req);

  always_comb begin
    ph_n       = (ph == PH_W'(PH_N - 1)) ? '0 : ph + PH_W'(1);
    mode_act_n = mode_act;
    blank_n    = blank;
    if (boundary) begin
      mode_act_n = mode_sel;
      blank_n    = (mode_sel != mode_act);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      mode_act <= PM_LORES;
      blank    <= 1'b1;
    end else begin
      ph       <= ph_n;
      mode_act <= mode_act_n;
      blank    <= blank_n;
    end
  end

endmodule

// File: rtl/palette_fmt.sv
module palette_fmt
  import palette_tmux_pkg::*;
#(
  parameter int unsigned COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph,
  input  logic             boundary,
  input  pmode_e           mode_act,
  input  logic             blank,
  input  logic [COL_W-1:0] rd_a,
  input  logic [COL_W-1:0] rd_b,
  output logic [COL_W-1:0] pix_rgb,
  output logic             pix_valid
);

  localparam int unsigned HALF = COL_W / 2;
  localparam int unsigned CH_W = COL_W / 3;
  localparam int unsigned SUB  = HALF / 3;

  logic [COL_W-1:0] lut_a, lut_a_n;
  logic [COL_W-1:0] lut_b, lut_b_n;
  logic [COL_W-1:0] exp_hi, exp_lo;
  logic [COL_W-1:0] rgb_n;
  logic             val_n;
  logic [HALF-1:0]  half_hi, half_lo;

  assign half_hi = lut_a[COL_W-1:HALF];
  assign half_lo = lut_a[HALF-1:0];

  // Widen each channel of a half-entry by repeating its bits (R4)
  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign exp_hi[c*CH_W +: CH_W] = {2{half_hi[c*SUB +: SUB]}};
    assign exp_lo[c*CH_W +: CH_W] = {2{half_lo[c*SUB +: SUB]}};
  end

  always_comb begin
    lut_a_n = lut_a;
    lut_b_n = lut_b;
    if (boundary) begin
      lut_a_n = rd_a;
      lut_b_n = rd_b;
    end
  end

  // Slot schedule within a slow cycle, indexed by phase before the edge
  always_comb begin
    rgb_n = pix_rgb;
    val_n = 1'b0;
    if (!boundary) begin
      if (blank) begin
        rgb_n = '0;
      end else begin
        case (mode_act)
          PM_HIRES: begin
            if (ph == PH_W'(1)) begin
              rgb_n = lut_a;
              val_n = 1'b1;
            end else if (ph == PH_W'(3)) begin
              rgb_n = lut_b;
              val_n = 1'b1;
            end
          end
          PM_DBL: begin
            if (ph == PH_W'(1)) begin
              rgb_n = exp_hi;
              val_n = 1'b1;
            end else if (ph == PH_W'(2)) begin
              rgb_n = exp_lo;
              val_n = 1'b1;
            end
          end
          default: begin
            if (ph == PH_W'(1)) begin
              rgb_n = lut_a;
              val_n = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_a     <= '0;
      lut_b     <= '0;
      pix_rgb   <= '0;
      pix_valid <= 1'b0;
    end else begin
      lut_a     <= lut_a_n;
      lut_b     <= lut_b_n;
      pix_rgb   <= rgb_n;
      pix_valid <= val_n;
    end
  end

endmodule

// File: rtl/palette_tmux.sv
module palette_tmux
  import palette_tmux_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_addr,
  input  logic [COL_W-1:0] cpu_wdata,
  input  logic [1:0]       mode_req,
  input  logic [IDX_W-1:0] sel_a,
  input  logic [IDX_W-2:0] sel_b,
  output logic [COL_W-1:0] pix_rgb,
  output logic             pix_valid
);

  logic [PH_W-1:0]  ph;
  logic             boundary;
  pmode_e           mode_sel;
  pmode_e           mode_act;
  logic             blank;
  logic [IDX_W-1:0] addr_a, addr_b;
  logic [COL_W-1:0] rd_a, rd_b;

  // High-res splits the file into two banks on the index side (R3, R9)
  assign addr_a = (mode_sel == PM_HIRES) ? {1'b0, sel_a[IDX_W-2:0]} : sel_a;
  assign addr_b = {1'b1, sel_b};

  palette_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .ph       (ph),
    .boundary (boundary),
    .mode_sel (mode_sel),
    .mode_act (mode_act),
    .blank    (blank)
  );

  palette_regs #(.IDX_W(IDX_W), .COL_W(COL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (boundary),
    .wr_en     (cpu_we),
    .wr_addr   (cpu_addr),
    .wr_data   (cpu_wdata),
    .rd_addr_a (addr_a),
    .rd_addr_b (addr_b),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b)
  );

  palette_fmt #(.COL_W(COL_W)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .boundary  (boundary),
    .mode_act  (mode_act),
    .blank     (blank),
    .rd_a      (rd_a),
    .rd_b      (rd_b),
    .pix_rgb   (pix_rgb),
    .pix_valid (pix_valid)
  );

endmodule

// File: rtl/palette_tmux_chk.sv
module palette_tmux_chk
  import palette_tmux_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [PH_W-1:0] ph,
  input pmode_e          mode_act,
  input logic            blank,
  input logic            pix_valid
);

  // R2: no pixel is ever presented right after a boundary edge
  a_r2_valid_slot: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (ph != PH_W'(1)));

  // R3: high-res pixels are spaced two clocks apart
  a_r3_hires_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == PM_HIRES && pix_valid) |=> !pix_valid);

  // R4: double-rate pixels come in back-to-back pairs
  a_r4_dbl_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == PM_DBL && pix_valid && ph == PH_W'(2)) |=> pix_valid);

  // R8: a blanked slow cycle presents nothing
  a_r8_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !pix_valid);

  // R8: the active mode moves only on a boundary edge
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_W'(1)) |-> $stable(mode_act));

endmodule

bind palette_tmux palette_tmux_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ph        (ph),
  .mode_act  (mode_act),
  .blank     (blank),
  .pix_valid (pix_valid)
);

// File: tb/tb_palette_tmux.sv
module tb_palette_tmux;

  localparam int IDX_W = 5;
  localparam int COL_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cpu_we;
  logic [IDX_W-1:0] cpu_addr;
  logic [COL_W-1:0] cpu_wdata;
  logic [1:0]       mode_req;
  logic [IDX_W-1:0] sel_a;
  logic [IDX_W-2:0] sel_b;
  logic [COL_W-1:0] pix_rgb;
  logic             pix_valid;

  always #5 clk = ~clk;

  palette_tmux #(.IDX_W(IDX_W), .COL_W(COL_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .mode_req  (mode_req),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .pix_rgb   (pix_rgb),
    .pix_valid (pix_valid)
  );

  int n_chk = 0;
  int n_err = 0;
  int pal_ref [32];
  bit pend_v;
  int pend_a, pend_d;
  int prev_nm;
  bit s_en [4];
  int s_a  [4];
  int s_d  [4];

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual %03h expected %03h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  function automatic int widen6(input int v);
    return ((((v >> 4) & 3) * 5) << 8) | ((((v >> 2) & 3) * 5) << 4) | ((v & 3) * 5);
  endfunction

  function automatic int fold(input int m);
    return (m == 3) ? 0 : m;
  endfunction

  function automatic int colour(input int i);
    return ((i * 12'h2d5) + 12'h3a7) & 12'hffe | 1;
  endfunction

  // One slow cycle: inputs before the boundary edge, checks after each edge
  task automatic slow_cycle(input int m, input int a, input int b, input string tag_in, input bit glitch);
    int nm, ea, va, vb, ev, er;
    bit blk;
    string tag;
    nm = fold(m);
    blk = (nm != prev_nm);
    prev_nm = nm;
    tag = blk ? "R8" : tag_in;
    ea = (nm == 1) ? (a % 16) : a;
    va = pal_ref[ea];
    vb = pal_ref[16 + b];
    if (pend_v) pal_ref[pend_a] = pend_d;
    pend_v = 1'b0;
    if (s_en[0]) begin
      pend_v = 1'b1; pend_a = s_a[0]; pend_d = s_d[0];
    end
    mode_req  = 2'(m);
    sel_a     = 5'(a);
    sel_b     = 4'(b);
    cpu_we    = s_en[0];
    cpu_addr  = 5'(s_a[0]);
    cpu_wdata = 12'(s_d[0]);
    for (int j = 0; j < 4; j++) begin
      @(posedge clk);
      @(negedge clk);
      ev = 0;
      er = 0;
      if (!blk) begin
        case (j)
          1: begin ev = 1; er = (nm == 2) ? widen6(va >> 6) : va; end
          2: begin ev = (nm == 2) ? 1 : 0; er = (nm == 2) ? widen6(va & 63) : va; end
          3: begin ev = (nm == 1) ? 1 : 0; er = (nm == 1) ? vb : ((nm == 2) ? widen6(va & 63) : va); end
          default: ;
        endcase
      end
      check(tag, "valid", int'(pix_valid), ev);
      if (j != 0) check(tag, "rgb", int'(pix_rgb), er);
      if (j < 3) begin
        cpu_we    = s_en[j+1];
        cpu_addr  = 5'(s_a[j+1]);
        cpu_wdata = 12'(s_d[j+1]);
        if (s_en[j+1]) begin
          pend_v = 1'b1; pend_a = s_a[j+1]; pend_d = s_d[j+1];
        end
        if (glitch) mode_req = 2'(m ^ 1);
      end else begin
        cpu_we = 1'b0;
      end
    end
    for (int k = 0; k < 4; k++) begin
      s_en[k] = 1'b0; s_a[k] = 0; s_d[k] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mode_req = 2'd0; sel_a = '0; sel_b = '0;
    pend_v = 1'b0; pend_a = 0; pend_d = 0; prev_nm = 0;
    for (int i = 0; i < 32; i++) pal_ref[i] = 0;
    for (int k = 0; k < 4; k++) begin s_en[k] = 1'b0; s_a[k] = 0; s_d[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "reset valid", int'(pix_valid), 0);
    check("R1", "reset rgb", int'(pix_rgb), 0);
    rst_n = 1'b1;

    // R1: every entry reads zero after reset
    for (int i = 0; i < 32; i++) slow_cycle(0, i, 0, "R1", 1'b0);

    // R6: load the palette, each lookup still sees the old value
    for (int i = 0; i < 32; i++) begin
      s_en[1] = 1'b1; s_a[1] = i; s_d[1] = colour(i);
      slow_cycle(0, i, 0, "R6", 1'b0);
    end

    // R2: low-resolution sweep of the loaded palette
    for (int i = 0; i < 32; i++) slow_cycle(0, 31 - i, 0, "R2", 1'b0);

    // R5: code 3 acts as low-resolution with no blank
    for (int i = 0; i < 8; i++) slow_cycle(3, i * 4 + 1, 0, "R5", 1'b0);

    // R3 and R9: two banks, upper index bit ignored
    for (int i = 0; i < 32; i++)
      slow_cycle(1, i, (i * 7) % 16, (i >= 16) ? "R9" : "R3", 1'b0);

    // R8: mode input toggling inside a slow cycle has no effect
    slow_cycle(1, 5, 9, "R8", 1'b1);
    slow_cycle(1, 21, 2, "R8", 1'b1);

    // R4: double-rate split of every entry
    for (int i = 0; i < 32; i++) slow_cycle(2, i, i % 16, "R4", 1'b0);

    // R7: two writes in one slow cycle, only the later lands
    s_en[1] = 1'b1; s_a[1] = 3; s_d[1] = 12'h5a5;
    s_en[2] = 1'b1; s_a[2] = 7; s_d[2] = 12'hc3c;
    slow_cycle(2, 3, 0, "R7", 1'b0);
    slow_cycle(2, 7, 0, "R7", 1'b0);
    slow_cycle(2, 3, 0, "R7", 1'b0);
    slow_cycle(2, 7, 0, "R7", 1'b0);

    // R6: write presented on the boundary edge waits one more boundary
    s_en[0] = 1'b1; s_a[0] = 10; s_d[0] = 12'h7e1;
    slow_cycle(2, 10, 0, "R6", 1'b0);
    slow_cycle(2, 10, 0, "R6", 1'b0);
    slow_cycle(2, 10, 0, "R6", 1'b0);

    // R8: back to low resolution, one blanked cycle then normal
    slow_cycle(0, 10, 0, "R8", 1'b0);
    slow_cycle(0, 10, 0, "R2", 1'b0);
    slow_cycle(3, 7, 0, "R5", 1'b0);

    finish_run();
  end

endmodule